// File: doc/BRIEF.md
# Split-Word 32-bit Integer Multiplier

This unit multiplies two 32-bit integers for a small RISC execution stage. It never hands back a 64-bit product in one go. An operation code picks one of two results. The first is the low word of the product. The second is the high word, read in one of three signedness variants: signed by signed, signed by unsigned, or unsigned by unsigned.

The build parameter `USE_HW_MULT` selects one of two engines.

- **Hardware engine.** It has four 16x16 partial multipliers. Three of them give the low word in a single cycle: the low-by-low product plus the two cross products, each cross product moved up by 16 bits. The high word takes two cycles. It uses all four partial products and then subtracts a signedness correction.
- **Logic-only engine.** It has no multipliers. It shifts and adds three multiplier bits per cycle and completes a low-word request in 11 cycles. It refuses the high-word codes by raising an unsupported flag alongside `done`.

Requests use a simple handshake. A request is taken when `start` is high while `busy` is low. `done` pulses for one cycle, and `result` is valid during that pulse.

Top module: `imul32_unit`

## Requirements
- R1: With `USE_HW_MULT`=1 and `op`=2'b00, `result` is bits 31:0 of `opa*opb`. `done` is high in the first cycle after the start cycle, `busy` stays low and `unsup` is 0.
- R2: With `USE_HW_MULT`=1 and `op`=2'b01, `result` is bits 63:32 of the product with both operands read as two's complement. `done` is high in the second cycle after the start cycle.
- R3: With `USE_HW_MULT`=1 and `op`=2'b10, `result` is bits 63:32 of the product with `opa` read as signed and `opb` as unsigned. `done` is high in the second cycle after the start cycle.
- R4: With `USE_HW_MULT`=1 and `op`=2'b11, `result` is bits 63:32 of the unsigned product. `done` is high in the second cycle after the start cycle.
- R5: In hardware mode, `busy` is high in the first cycle after a high-word start. A `start` seen while `busy` is high is ignored: it brings no extra `done` and leaves the pending result unchanged.
- R6: With `USE_HW_MULT`=0 and `op`=2'b00, `result` is bits 31:0 of the product. `done` is high in the eleventh cycle after the start cycle, `busy` is high in cycles 1 to 10, and a `start` during those cycles is ignored.
- R7: With `USE_HW_MULT`=0 and `op`≠2'b00, `done` and `unsup` are high in the first cycle after the start cycle, with `result`=0.
- R8: Each accepted request gives exactly one `done` pulse, and `busy` is low whenever `done` is high. A request may be accepted in the cycle that shows `done`.
- R9: A synchronous active-high `rst` clears `busy`, `done` and `unsup`. It drops any request in flight, so that request never signals `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken when `busy` is low |
| op | input | 2 | 00 low word, 01 high s*s, 10 high s*u, 11 high u*u |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| busy | output | 1 | A multi-cycle request is in progress |
| done | output | 1 | One-cycle pulse: `result` valid |
| unsup | output | 1 | With `done`: operation not available in this build |
| result | output | 32 | Selected product word |

## Verification
Fixed corner operands are run through all four codes, and each one isolates a different fault:

| Operands | What it isolates |
|----------|------------------|
| 0x80000000 x 0x80000000 | Correction subtracted with the wrong sign; high s*u differs from s*s |
| 0xFFFFFFFF x 0xFFFFFFFF | Carry out of the summed cross products; both signed corrections at once |
| zero times any value | Any term that leaks in when a partial product should vanish |
| 0x7FFFFFFF x 0x80000000, and 1 x 0xFFFFFFFF | Which operand is taken as signed in the mixed variant |

Random operands then cover general carry patterns between the partial products.

Timing is checked as follows:
- The cycle in which `done` lands is compared per engine.
- Junk requests sent during busy cycles show whether they are really ignored.
- Back-to-back requests, including one taken in a `done` cycle, show that nothing is lost or repeated.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam int XLEN       = 32;
    localparam int HALF       = XLEN / 2;
    localparam int STEP_BITS  = 3;
    localparam int ITER_STEPS = (XLEN + STEP_BITS - 1) / STEP_BITS;
    localparam int CNT_W      = $clog2(ITER_STEPS);
    localparam int NUM_PARTS  = 4;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [HALF-1:0]   half_t;
    typedef logic [2*HALF-1:0] prod_t;
    typedef logic [2*XLEN-1:0] dword_t;

    typedef enum logic [1:0] {
        OP_LO    = 2'b00,
        OP_HI_SS = 2'b01,
        OP_HI_SU = 2'b10,
        OP_HI_UU = 2'b11
    } mop_e;

    typedef enum logic { F_IDLE, F_HIGH } fstate_e;
    typedef enum logic { I_IDLE, I_RUN  } istate_e;

    // Registered partial products plus the signedness correction for the high word
    typedef struct packed {
        prod_t ll;
        prod_t hl;
        prod_t lh;
        prod_t hh;
        word_t corr;
    } hi_stage_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        logic  unsup;
        word_t result;
    } mul_resp_t;

    function automatic logic first_signed(mop_e op);
        return (op == OP_HI_SS) || (op == OP_HI_SU);
    endfunction

    function automatic logic second_signed(mop_e op);
        return op == OP_HI_SS;
    endfunction

    // Amount to subtract from the unsigned high word to obtain the signed one
    function automatic word_t sign_corr(word_t a, word_t b, mop_e op);
        word_t c;
        c = '0;
        if (first_signed(op) && a[XLEN-1])
            c = c + b;
        if (second_signed(op) && b[XLEN-1])
            c = c + a;
        return c;
    endfunction

    // One shift-and-add step: consume STEP_BITS multiplier bits
    function automatic word_t shift_add_step(word_t acc, word_t mc, word_t mp);
        word_t s;
        s = acc;
        for (int k = 0; k < STEP_BITS; k++) begin
            if (mp[k])
                s = s + (mc << k);
        end
        return s;
    endfunction

endpackage

// File: rtl/imul_part16.sv
module imul_part16 #(
    parameter int W = 16
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    assign p = x * y;
endmodule

// File: rtl/imul_fast.sv
module imul_fast
    import imul_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mop_e      op,
    input  word_t     a,
    input  word_t     b,
    output mul_resp_t resp
);
    prod_t     part [NUM_PARTS];
    fstate_e   state;
    hi_stage_t stg;
    logic      done_q;
    word_t     res_q;
    word_t     lo_word;
    dword_t    full;
    word_t     hi_word;
    logic      busy;

    // part[0]=lo*lo, part[1]=hi*lo, part[2]=lo*hi, part[3]=hi*hi
    genvar g;
    for (g = 0; g < NUM_PARTS; g++) begin : g_part
        localparam bit X_HI = (g % 2) == 1;
        localparam bit Y_HI = g >= 2;
        half_t x_sel;
        half_t y_sel;
        assign x_sel = X_HI ? a[XLEN-1:HALF] : a[HALF-1:0];
        assign y_sel = Y_HI ? b[XLEN-1:HALF] : b[HALF-1:0];
        imul_part16 #(.W(HALF)) u_mul (
            .x(x_sel),
            .y(y_sel),
            .p(part[g])
        );
    end

    assign busy = (state == F_HIGH);

    always_comb begin
        lo_word = part[0] + ((part[1] + part[2]) << HALF);
        full    = {stg.hh, {XLEN{1'b0}}}
                + (dword_t'(stg.hl) << HALF)
                + (dword_t'(stg.lh) << HALF)
                + dword_t'(stg.ll);
        hi_word = full[2*XLEN-1:XLEN] - stg.corr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= F_IDLE;
            done_q <= 1'b0;
            res_q  <= '0;
            stg    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                F_IDLE: begin
                    if (start) begin
                        if (op == OP_LO) begin
                            res_q  <= lo_word;
                            done_q <= 1'b1;
                        end else begin
                            stg   <= '{ll: part[0], hl: part[1], lh: part[2],
                                       hh: part[3], corr: sign_corr(a, b, op)};
                            state <= F_HIGH;
                        end
                    end
                end
                F_HIGH: begin
                    res_q  <= hi_word;
                    done_q <= 1'b1;
                    state  <= F_IDLE;
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    assign resp = '{busy: busy, done: done_q, unsup: 1'b0, result: res_q};

    AST_LO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_LO) |=> (done_q && !busy)); // R1

    AST_HI_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != OP_LO) |=> (busy && !done_q)); // R2

    AST_HI_SECOND_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done_q && !busy)); // R4

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(stg)); // R5

endmodule

// File: rtl/imul_iter.sv
module imul_iter
    import imul_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mop_e      op,
    input  word_t     a,
    input  word_t     b,
    output mul_resp_t resp
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER_STEPS - 1);

    istate_e          state;
    logic [CNT_W-1:0] cnt;
    word_t            acc;
    word_t            mc;
    word_t            mp;
    word_t            res_q;
    logic             done_q;
    logic             unsup_q;
    word_t            step_first;
    word_t            step_run;
    logic             busy;

    assign busy       = (state == I_RUN);
    assign step_first = shift_add_step('0, a, b);
    assign step_run   = shift_add_step(acc, mc, mp);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= I_IDLE;
            cnt     <= '0;
            acc     <= '0;
            mc      <= '0;
            mp      <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
            case (state)
                I_IDLE: begin
                    if (start) begin
                        if (op != OP_LO) begin
                            res_q   <= '0;
                            done_q  <= 1'b1;
                            unsup_q <= 1'b1;
                        end else begin
                            acc   <= step_first;
                            mc    <= a << STEP_BITS;
                            mp    <= b >> STEP_BITS;
                            cnt   <= CNT_W'(1);
                            state <= I_RUN;
                        end
                    end
                end
                I_RUN: begin
                    acc <= step_run;
                    mc  <= mc << STEP_BITS;
                    mp  <= mp >> STEP_BITS;
                    if (cnt == LAST) begin
                        res_q  <= step_run;
                        done_q <= 1'b1;
                        state  <= I_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= I_IDLE;
            endcase
        end
    end

    assign resp = '{busy: busy, done: done_q, unsup: unsup_q, result: res_q};

    AST_NO_HIGH_WORD: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != OP_LO) |=> (done_q && unsup_q && res_q == '0)); // R7

    AST_UNSUP_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        unsup_q |-> done_q); // R7

    AST_LO_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_LO) |=> (busy && !done_q)); // R6

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0 && cnt <= LAST)); // R6

    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST) |=> (done_q && !busy)); // R6

endmodule

// File: rtl/imul32_unit.sv
module imul32_unit
    import imul_pkg::*;
#(
    parameter bit USE_HW_MULT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic            unsup,
    output logic [XLEN-1:0] result
);
    mul_resp_t resp;
    mop_e      op_e;

    assign op_e = mop_e'(op);

    if (USE_HW_MULT) begin : g_fast
        imul_fast u_fast (
            .clk  (clk),
            .rst  (rst),
            .start(start),
            .op   (op_e),
            .a    (opa),
            .b    (opb),
            .resp (resp)
        );
    end else begin : g_iter
        imul_iter u_iter (
            .clk  (clk),
            .rst  (rst),
            .start(start),
            .op   (op_e),
            .a    (opa),
            .b    (opb),
            .resp (resp)
        );
    end

    assign busy   = resp.busy;
    assign done   = resp.done;
    assign unsup  = resp.unsup;
    assign result = resp.result;

    AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy && !done && !unsup)); // R9

endmodule

// File: tb/tb_imul32_unit.sv
module tb_imul32_unit;

    typedef struct {
        logic [31:0] res;
        logic        uns;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_h = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        busy_h, done_h, unsup_h;
    logic        busy_i, done_i, unsup_i;
    logic [31:0] res_h, res_i;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    string idle_tag = "R8";
    exp_t  qh[$];
    exp_t  qi[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    imul32_unit #(.USE_HW_MULT(1'b1)) dut (
        .clk(clk), .rst(rst), .start(start_h), .op(op), .opa(a), .opb(b),
        .busy(busy_h), .done(done_h), .unsup(unsup_h), .result(res_h));

    imul32_unit #(.USE_HW_MULT(1'b0)) dut_iter (
        .clk(clk), .rst(rst), .start(start_i), .op(op), .opa(a), .opb(b),
        .busy(busy_i), .done(done_i), .unsup(unsup_i), .result(res_i));

    function automatic logic [31:0] model(logic [1:0] o, logic [31:0] x, logic [31:0] y);
        logic [63:0] xs, ys, xu, yu, p;
        xs = {{32{x[31]}}, x};
        ys = {{32{y[31]}}, y};
        xu = {32'b0, x};
        yu = {32'b0, y};
        case (o)
            2'b00:   begin p = xu * yu; return p[31:0];  end
            2'b01:   begin p = xs * ys; return p[63:32]; end
            2'b10:   begin p = xs * yu; return p[63:32]; end
            default: begin p = xu * yu; return p[63:32]; end
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_h(logic [1:0] o, logic [31:0] x, logic [31:0] y, string extra);
        exp_t e;
        e.res = model(o, x, y);
        e.uns = 1'b0;
        e.due = cyc + ((o == 2'b00) ? 1 : 2);
        case (o)
            2'b00:   e.tag = "R1";
            2'b01:   e.tag = "R2";
            2'b10:   e.tag = "R3";
            default: e.tag = "R4";
        endcase
        e.tag = {e.tag, extra};
        qh.push_back(e);
    endtask

    task automatic expect_i(logic [1:0] o, logic [31:0] x, logic [31:0] y, string extra);
        exp_t e;
        if (o == 2'b00) begin
            e.res = model(o, x, y);
            e.uns = 1'b0;
            e.due = cyc + 11;
            e.tag = {"R6", extra};
        end else begin
            e.res = '0;
            e.uns = 1'b1;
            e.due = cyc + 1;
            e.tag = "R7";
        end
        qi.push_back(e);
    endtask

    task automatic drive_raw(logic sh, logic si, logic [1:0] o, logic [31:0] x, logic [31:0] y);
        start_h = sh;
        start_i = si;
        op      = o;
        a       = x;
        b       = y;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30 && (qh.size() != 0 || qi.size() != 0); i++)
            @(negedge clk);
        check("R8", "missing done (hw)", 32'(qh.size()), 32'd0);
        check("R8", "missing done (iter)", 32'(qi.size()), 32'd0);
        qh.delete();
        qi.delete();
    endtask

    // One request to both engines, optionally followed by a junk start while busy
    task automatic run_one(logic [1:0] o, logic [31:0] x, logic [31:0] y, bit junk);
        @(negedge clk);
        drive_raw(1'b1, 1'b1, o, x, y);
        expect_h(o, x, y, junk ? " R5" : "");
        expect_i(o, x, y, "");
        @(negedge clk);
        check("R5", "busy after start (hw)", {31'b0, busy_h}, {31'b0, o != 2'b00});
        check("R6", "busy after start (iter)", {31'b0, busy_i}, {31'b0, o == 2'b00});
        if (junk)
            drive_raw(o != 2'b00, o == 2'b00, ~o, ~x ^ $urandom, y + 32'd77);
        else
            drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
        @(negedge clk);
        drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
        wait_idle();
    endtask

    task automatic mon_side(string who, logic dn, logic un, logic [31:0] r, ref exp_t q[$]);
        exp_t e;
        if (dn) begin
            if (q.size() == 0) begin
                check(idle_tag, {"unexpected done ", who}, 32'd1, 32'd0);
            end else begin
                e = q.pop_front();
                check(e.tag, {"result ", who}, r, e.res);
                check(e.tag, {"unsup ", who}, {31'b0, un}, {31'b0, e.uns});
                check(e.tag, {"done cycle ", who}, 32'(cyc), 32'(e.due));
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            mon_side("hw", done_h, unsup_h, res_h, qh);
            mon_side("iter", done_i, unsup_i, res_i, qi);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] corner_a [6];
        logic [31:0] corner_b [6];
        corner_a = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678,
                     32'h7FFF_FFFF, 32'h0000_0001};
        corner_b = '{32'h8000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_0000,
                     32'h8000_0000, 32'hFFFF_FFFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "busy after reset (hw)", {31'b0, busy_h}, 32'd0);
        check("R9", "done after reset (hw)", {31'b0, done_h}, 32'd0);
        check("R9", "busy after reset (iter)", {31'b0, busy_i}, 32'd0);
        check("R9", "unsup after reset (iter)", {31'b0, unsup_i}, 32'd0);

        for (int c = 0; c < 6; c++)
            for (int o = 0; o < 4; o++)
                run_one(2'(o), corner_a[c], corner_b[c], 1'b0);

        for (int n = 0; n < 40; n++)
            run_one(2'($urandom_range(0, 3)), $urandom, $urandom, n[0]);

        // Back-to-back low words on the hardware engine; iter ignores the second start
        @(negedge clk);
        drive_raw(1'b1, 1'b1, 2'b00, 32'hCAFE_0123, 32'h0F0F_F0F0);
        expect_h(2'b00, 32'hCAFE_0123, 32'h0F0F_F0F0, " R8");
        expect_i(2'b00, 32'hCAFE_0123, 32'h0F0F_F0F0, " R8");
        @(negedge clk);
        drive_raw(1'b1, 1'b1, 2'b00, 32'h8765_4321, 32'hFFFF_0001);
        expect_h(2'b00, 32'h8765_4321, 32'hFFFF_0001, " R8");
        @(negedge clk);
        drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
        wait_idle();

        // High word, then a new request taken in the cycle showing done
        @(negedge clk);
        drive_raw(1'b1, 1'b0, 2'b01, 32'hF000_0001, 32'h0000_0003);
        expect_h(2'b01, 32'hF000_0001, 32'h0000_0003, " R8");
        @(negedge clk);
        drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
        @(negedge clk);
        check("R8", "done before reuse", {31'b0, done_h}, 32'd1);
        drive_raw(1'b1, 1'b0, 2'b11, 32'hFFFF_FFFF, 32'h0000_0002);
        expect_h(2'b11, 32'hFFFF_FFFF, 32'h0000_0002, " R8");
        @(negedge clk);
        drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
        wait_idle();

        // Reset aborts an in-flight request on each engine
        idle_tag = "R9";
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            drive_raw(k == 0, k == 1, (k == 0) ? 2'b01 : 2'b00, 32'h1357_9BDF, 32'h2468_ACE0);
            @(negedge clk);
            drive_raw(1'b0, 1'b0, 2'b00, '0, '0);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            check("R9", "busy after abort (hw)", {31'b0, busy_h}, 32'd0);
            check("R9", "busy after abort (iter)", {31'b0, busy_i}, 32'd0);
            check("R9", "done after abort", {31'b0, done_h | done_i}, 32'd0);
            repeat (14) @(negedge clk);
        end
        idle_tag = "R8";

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule